// File: doc/BRIEF.md
# Programmable Clock Divider with Glitch-Free Output Enable

This block builds a slow square-wave clock from a fast timebase in two stages. A prescaler divides the master clock by M (1, 2 or 4) to form an internal clock, MCLK. A second counter divides MCLK by N, which may be any value from 1 to 513, and drives the main output. MCLK also appears on a reference output. Software can switch the reference output off, and the output-enable input never affects it.

The output-enable input is asynchronous. A two-flop synchronizer samples it on MCLK rising edges before it gates the main output. The gating never shortens a high pulse. While the output is off, the divide-by-N counter is held at zero, so every restart begins with a full high phase at a fixed delay. Divide-by-one mode has its own path. In that mode the output is MCLK ANDed with a gate flop that changes only while MCLK is low.

The block runs from one clock, `clk`, at twice the master oscillator rate. One `clk` cycle is one half-period of the master oscillator, so every output is a register or an AND of two registers. All configuration inputs are static while the block runs.

Top module: `clkdiv_gated`

## Requirements
- R1: `cfg_m_sel` selects the prescaler: 2'b00 gives M=1, 2'b01 gives M=2, and 2'b10 or 2'b11 gives M=4. MCLK has a period of 2*M `clk` cycles and a 50% duty cycle.
- R2: While enabled, `main_out` has a period of 2*M*N `clk` cycles for every N from 1 to 513. Its rising edges fall only on MCLK rising edges.
- R3: For N of 2 or more, `main_out` is high for 2*M*floor(N/2) `clk` cycles of each period, from count 0 up to the count floor(N/2). For N=1, it is high for the M cycles in which MCLK is high.
- R4: `ref_out` follows MCLK when `cfg_ref_en` is 1 and stays at 0 when it is 0. `out_en` has no effect on it.
- R5: `out_en` passes through two flops that load on MCLK rising edges. After the first sampling edge that sees it high, `main_out` rises on the second following MCLK rising edge. Raising `out_en` just after an MCLK rise therefore gives a first rise on the third MCLK rise.
- R6: For N of 2 or more, if the synchronized enable goes low while `main_out` is high, the high phase completes at its full length. The output then stays low with no further rising edge.
- R7: For N of 2 or more, the disable takes effect at the first MCLK rise at which the synchronized enable is already low. A pulse that starts before that edge is emitted in full. When the enable drops during the final MCLK period before the count wraps, exactly one more pulse appears. When the enable drops right after a falling edge of `main_out`, no further pulse appears.
- R8: While the output is disabled, the divide-by-N counter is held at zero. The first pulse after re-enable has the full high length given in R3.
- R9: For N=1, the gate flop changes only on MCLK falling edges. When the enable is sampled low at an MCLK rising edge, the pulse of that edge and the pulse of the next MCLK rise are emitted, and the output then stays low.
- R10: `rst_n` is asynchronous and active low. During reset, `main_out` and `ref_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase at twice the master oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_m_sel | input | 2 | Prescaler select (see R1) |
| cfg_n | input | N_W | Main divide ratio N, 1 to 513 |
| cfg_ref_en | input | 1 | Turns on the reference output |
| out_en | input | 1 | Asynchronous output enable for the main output |
| main_out | output | 1 | Main divided clock, MCLK / N |
| ref_out | output | 1 | Reference output carrying MCLK |

## Verification
The bench builds the block with the default N_W of 10, so the table can reach the largest ratio, N=513, next to N=1, 2, 3, 5 and 8. All three prescaler values appear in that set. Because the divide-by-one path and the counter path both come from one build, the bench can compare their disable behaviour with the same timing reference, the rising edges of `ref_out`. It releases and drops the enable just after MCLK edges at chosen counter phases. This makes the full-pulse completion, the one-extra-pulse case near the wrap and the two-pulse tail of divide-by-one reproducible to the cycle.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Prescaler selections
  typedef enum logic [1:0] {
    PS_DIV1 = 2'b00,
    PS_DIV2 = 2'b01,
    PS_DIV4 = 2'b10
  } ps_sel_e;

  localparam int unsigned MAX_HALF_TICKS = 4;

  // clk cycles per MCLK half-period for a prescaler select
  function automatic logic [2:0] half_ticks(input logic [1:0] sel);
    case (sel)
      PS_DIV1: half_ticks = 3'd1;
      PS_DIV2: half_ticks = 3'd2;
      default: half_ticks = 3'd4;
    endcase
  endfunction

  // count at which the main output drops for N >= 2
  function automatic int unsigned high_span(input int unsigned n);
    high_span = n / 2;
  endfunction

endpackage

// File: rtl/clkdiv_prescale.sv
`timescale 1ns/1ps
module clkdiv_prescale
  import clkdiv_pkg::*;
#(
  parameter int unsigned MAX_TICKS = MAX_HALF_TICKS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_m_sel,
  output logic       mclk_q,
  output logic       rise_evt,
  output logic       fall_evt
);
  localparam int unsigned PC_W = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] last_pc;
  logic            tog;

  assign last_pc  = PC_W'(half_ticks(cfg_m_sel) - 3'd1);
  assign tog      = (pc == last_pc);
  assign rise_evt = tog & ~mclk_q;
  assign fall_evt = tog & mclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      mclk_q <= 1'b0;
    end else begin
      pc     <= tog ? '0 : pc + PC_W'(1);
      mclk_q <= mclk_q ^ tog;
    end
  end

  AST_MCLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mclk_q) |-> ($past(pc) == last_pc)); // R1

endmodule

// File: rtl/clkdiv_en_sync.sv
`timescale 1ns/1ps
module clkdiv_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  input  logic en_async,
  output logic en_s
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '0;
    else if (rise_evt) sh <= {sh[STAGES-2:0], en_async};
  end

  assign en_s = sh[STAGES-1];

  AST_SYNC_ON_MCLK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_s) |-> $past(rise_evt)); // R5

endmodule

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
module clkdiv_gate #(
  parameter int unsigned N_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rise_evt,
  input  logic           fall_evt,
  input  logic           mclk_q,
  input  logic           en_s,
  input  logic [N_W-1:0] cfg_n,
  output logic           main_out
);
  logic [N_W-1:0] cnt;
  logic [N_W-1:0] nc;
  logic [N_W-1:0] half;
  logic           run_q;
  logic           main_q;
  logic           gate_q;
  logic           one_mode;
  logic           stop_now;

  assign one_mode = (cfg_n == N_W'(1));
  assign half     = N_W'(clkdiv_pkg::high_span(32'(cfg_n)));
  assign nc       = (cnt == cfg_n - N_W'(1)) ? '0 : cnt + N_W'(1);
  // leave only when disabled and no high phase is still running
  assign stop_now = run_q && !en_s && !(main_q && (nc < half));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt    <= '0;
      main_q <= 1'b0;
    end else if (rise_evt && !one_mode) begin
      if (run_q) begin
        if (stop_now) begin
          run_q  <= 1'b0;
          cnt    <= '0;
          main_q <= 1'b0;
        end else begin
          cnt    <= nc;
          main_q <= (nc < half);
        end
      end else if (en_s) begin
        run_q  <= 1'b1;
        cnt    <= '0;
        main_q <= 1'b1;
      end else begin
        cnt    <= '0;
        main_q <= 1'b0;
      end
    end
  end

  // divide-by-one gate: loads only as MCLK goes low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gate_q <= 1'b0;
    else if (fall_evt) gate_q <= en_s & one_mode;
  end

  assign main_out = one_mode ? (mclk_q & gate_q) : main_q;

  AST_NO_CUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!one_mode && $fell(main_q)) |-> ($past(cnt) == half - N_W'(1))); // R6
  AST_CNT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt == '0)); // R8
  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_q) |-> $past(en_s)); // R7
  AST_GATE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> !mclk_q); // R9
  AST_RISE_ON_MCLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_out) |-> $rose(mclk_q)); // R2

endmodule

// File: rtl/clkdiv_gated.sv
`timescale 1ns/1ps
module clkdiv_gated #(
  parameter int unsigned N_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cfg_m_sel,
  input  logic [N_W-1:0] cfg_n,
  input  logic           cfg_ref_en,
  input  logic           out_en,
  output logic           main_out,
  output logic           ref_out
);
  logic mclk_q;
  logic rise_evt;
  logic fall_evt;
  logic en_s;

  clkdiv_prescale u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_m_sel(cfg_m_sel),
    .mclk_q   (mclk_q),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  clkdiv_en_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_evt(rise_evt),
    .en_async(out_en),
    .en_s    (en_s)
  );

  clkdiv_gate #(.N_W(N_W)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_evt(rise_evt),
    .fall_evt(fall_evt),
    .mclk_q  (mclk_q),
    .en_s    (en_s),
    .cfg_n   (cfg_n),
    .main_out(main_out)
  );

  assign ref_out = mclk_q & cfg_ref_en;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!main_out && !ref_out)); // R10

endmodule

// File: tb/sim_clkdiv_gated.sv
`timescale 1ns/1ps
module sim_clkdiv_gated;
  localparam int CLK_P = 10;
  localparam int NV    = 8;
  localparam int unsigned VM [NV] = '{0, 1, 2, 0, 1, 2, 0, 1};
  localparam int unsigned VN [NV] = '{1, 1, 1, 2, 3, 5, 8, 513};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_m_sel = 2'b00;
  logic [9:0] cfg_n = 10'd4;
  logic       cfg_ref_en = 1'b1;
  logic       out_en = 1'b0;
  logic       main_out;
  logic       ref_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  clkdiv_gated #(.N_W(10)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_m_sel(cfg_m_sel), .cfg_n(cfg_n),
    .cfg_ref_en(cfg_ref_en), .out_en(out_en),
    .main_out(main_out), .ref_out(ref_out)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; failures++;
      $display("FAIL R2 watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int m_of(input int unsigned sel);
    return (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int unsigned msel, input int unsigned n,
                       input logic ren, input logic en);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_m_sel = msel[1:0];
    cfg_n = n[9:0];
    cfg_ref_en = ren;
    out_en = en;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic count_main_rises(input int ticks, output int rises);
    logic prev;
    rises = 0;
    prev = main_out;
    repeat (ticks) begin
      @(negedge clk);
      if (main_out && !prev) rises++;
      prev = main_out;
    end
  endtask

  // raise out_en just after an MCLK rise; expect main_out up on the third rise
  task automatic en_rise_check(input string tag, output time t_rise);
    logic s1, s2, s3;
    @(posedge ref_out); #1 out_en = 1'b1;
    @(posedge ref_out); #1 s1 = main_out;
    @(posedge ref_out); t_rise = $time; #1 s2 = main_out;
    // s2 taken at the second rise, s3 at the third
    @(posedge ref_out); t_rise = $time; #1 s3 = main_out;
    chk({tag, " low on 1st rise"}, int'(s1), 0);
    chk({tag, " low on 2nd rise"}, int'(s2), 0);
    chk({tag, " high on 3rd rise"}, int'(s3), 1);
  endtask

  initial begin
    time t0, t1, t2, tr;
    int rises;
    int hi;

    // R10: outputs quiet in reset
    repeat (2) @(negedge clk);
    chk("R10 main_out in reset", int'(main_out), 0);
    chk("R10 ref_out in reset", int'(ref_out), 0);

    // vector table: R1 ref period, R2 main period, R3 high time
    for (int i = 0; i < NV; i++) begin
      int m, n, exp_hi;
      m = m_of(VM[i]);
      n = int'(VN[i]);
      exp_hi = (n == 1) ? m : 2 * m * (n / 2);
      apply(VM[i], VN[i], 1'b1, 1'b1);
      @(posedge main_out); t0 = $time;
      @(negedge main_out); t1 = $time;
      @(posedge main_out); t2 = $time;
      chk($sformatf("R2 period m=%0d n=%0d", m, n), int'((t2 - t0) / CLK_P), 2 * m * n);
      chk($sformatf("R3 high m=%0d n=%0d", m, n), int'((t1 - t0) / CLK_P), exp_hi);
      #1;
      @(posedge ref_out); t0 = $time;
      @(posedge ref_out); t1 = $time;
      chk($sformatf("R1 ref period m=%0d", m), int'((t1 - t0) / CLK_P), 2 * m);
    end

    // R4: reference runs with the output disabled, and stops when switched off
    apply(0, 8, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    begin
      logic prev;
      int rr, hh;
      rr = 0; hh = 0; prev = ref_out;
      repeat (40) begin
        @(negedge clk);
        if (ref_out && !prev) rr++;
        if (main_out) hh++;
        prev = ref_out;
      end
      chk("R4 ref toggles with out_en=0", int'(rr >= 19), 1);
      chk("R4 main_out idle with out_en=0", hh, 0);
      cfg_ref_en = 1'b0;
      hh = 0;
      repeat (20) begin
        @(negedge clk);
        if (ref_out) hh++;
      end
      chk("R4 ref_out off when disabled", hh, 0);
    end

    // R5: enable latency, N >= 2
    apply(1, 4, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    en_rise_check("R5 n=4", tr);

    // R6: disable during a high phase
    apply(0, 8, 1'b1, 1'b1);
    @(posedge main_out); t0 = $time; #1 out_en = 1'b0;
    @(negedge main_out); t1 = $time;
    chk("R6 full high phase", int'((t1 - t0) / CLK_P), 8);
    count_main_rises(60, rises);
    chk("R6 no pulse after disable", rises, 0);

    // R8: re-enable restarts from count 0 with a full pulse
    en_rise_check("R8 restart", tr);
    @(negedge main_out); t1 = $time;
    chk("R8 first pulse full length", int'((t1 - tr) / CLK_P), 8);

    // R7: disable just after a falling edge, no further pulse
    @(posedge main_out); #1;
    @(negedge main_out); #1 out_en = 1'b0;
    count_main_rises(60, rises);
    chk("R7 no extra pulse", rises, 0);

    // R7: disable in last period before wrap, exactly one extra pulse
    out_en = 1'b1;
    @(posedge main_out); #1;
    @(negedge main_out); #1;
    repeat (3) @(posedge ref_out);
    #1 out_en = 1'b0;
    count_main_rises(60, rises);
    chk("R7 one extra pulse at wrap", rises, 1);

    // R9: divide-by-one disable tail and enable latency
    apply(1, 1, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    @(posedge ref_out); #1 out_en = 1'b0;
    count_main_rises(60, rises);
    chk("R9 two pulses after disable", rises, 2);
    hi = 0;
    repeat (20) begin
      @(negedge clk);
      if (main_out) hi++;
    end
    chk("R9 held low", hi, 0);
    en_rise_check("R9 n=1", tr);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule